// File: doc/BRIEF.md
# Multi-Channel Fractional Resampler Phase Controller

This block steers a shared multi-channel fractional resampling filter. The channels take turns, one per clock, in round-robin order. On a channel's turn the block reads that channel's stored phase and mode from a per-channel state array. It combines them with the channel's input-valid flag and ratio code, and decides three things: whether the filter's sample delay line shifts in the new sample, whether an output sample is due, and which coefficient set that output uses. It then writes the updated phase and mode back before the channel's next turn. A single phase engine serves every channel, and each channel may run a different conversion ratio.

Each channel is in one of three modes. RUN is the normal mode, in which a valid input is shifted in and produces an output. HOLD means an output is due before the next input arrives, so the delay line keeps its contents and an output is produced. SKIP means the next valid input is shifted in but produces no output. The transitions are RUN→HOLD, RUN→SKIP, RUN→RUN, HOLD→RUN, HOLD→SKIP, HOLD→HOLD, SKIP→RUN and SKIP→SKIP, and each is chosen by the phase arithmetic in R4 to R6. A change of ratio code forces the channel back to RUN with phase zero.

The phase steps are small integers. Each ratio occupies as many consecutive coefficient addresses as its input step, and the ratios are stacked in code order.

Top module: `srcpc_phase_ctrl`

## Requirements
- R1: The `slot` output is 0 while reset is asserted. It advances by one each clock and wraps from NCH-1 to 0. The inputs presented in a cycle belong to the channel shown on `slot`.
- R2: During reset, and for the first turn after reset is released, all registered outputs are 0. Every channel starts in RUN with phase 0 and recorded ratio code 0.
- R3: The ratio codes map to (input step, output step) as follows: 0 = bypass (1,1), 1 = 3/4 (3,4), 2 = 5/8 (5,8), 3 = 5/6 (5,6), 4 = 4/3 (4,3), 5 = 8/5 (8,5), 6 = 6/5 (6,5). Code 7 behaves exactly as bypass, including base address 0. In bypass, every valid input gives exactly one output.
- R4: On a RUN turn with `in_valid`=1, both `shift_en` and `out_valid` are set. The sum is phase plus the output step. If the sum is below the input step, the channel moves to HOLD with phase equal to the sum. Otherwise the phase becomes the sum minus the input step, and the mode becomes SKIP if (sum >> 1) is at least the input step, else RUN.
- R5: On a HOLD turn, `out_valid`=1 and `shift_en`=0, and `in_valid` is ignored. The state update is the same as in R4.
- R6: On a SKIP turn with `in_valid`=1, `shift_en`=1 and `out_valid`=0. The mode becomes SKIP if (phase >> 1) is at least the input step, else RUN. The phase becomes phase minus the input step.
- R7: On a RUN or SKIP turn with `in_valid`=0, `shift_en` and `out_valid` are 0 and the channel's state is unchanged.
- R8: When `out_valid`=1, `coef_addr` equals the ratio's base address plus the channel's phase before the update. The base address of a code is the sum of the input steps of all lower codes (0,1,4,9,14,18,26). When `out_valid`=0, `coef_addr` is 0.
- R9: `shift_en`, `out_valid`, `coef_addr` and `out_chan` are registered. They appear one clock after the turn, and `out_chan` carries the channel served.
- R10: If a channel's ratio code differs from the code recorded at its previous turn, the turn starts from RUN with phase 0. The new code is then recorded.
- R11: A 5/8 channel with a steady input gives 5 outputs for 8 inputs. A 4/3 channel gives 4 outputs by the time it has taken 3 inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A new sample is available for the channel on `slot` |
| ratio_code | input | 3 | Ratio code of the channel on `slot` |
| slot | output | CH_W | Channel served this cycle |
| shift_en | output | 1 | Delay line takes the new sample (0 = keep) |
| out_valid | output | 1 | An output sample is computed this turn |
| out_chan | output | CH_W | Channel that the registered outputs belong to |
| coef_addr | output | ADDR_W | Coefficient set address |

## Verification
The main function is driven with steady valid inputs on all channels in bypass, which separates the one-to-one path from any phase arithmetic. A mixed run gives each channel its own ratio and a different sparse valid pattern, including the reserved code. That run exposes cross-talk between the channels' stored states and any wrong HOLD or SKIP decision. Single-channel 5/8 and 4/3 runs check long-run output counts, which catch an arithmetic slip that a per-turn model with the same slip would miss. Ratio switching mid-stream and an all-idle stretch show the restart rule and the preservation of state across idle turns.

// File: rtl/srcpc_pkg.sv
package srcpc_pkg;

    localparam int CODE_W    = 3;
    localparam int STEP_W    = 4;
    localparam int PH_W      = 5;
    localparam int ADDR_W    = 5;
    localparam int NUM_CODES = 1 << CODE_W;

    typedef enum logic [1:0] {
        MD_RUN  = 2'd0,
        MD_HOLD = 2'd1,
        MD_SKIP = 2'd2
    } chan_mode_e;

    // Input-side step per ratio code; the reserved code falls back to bypass.
    function automatic logic [STEP_W-1:0] step_in_of(input logic [CODE_W-1:0] code);
        case (code)
            3'd1:    step_in_of = 4'd3;
            3'd2:    step_in_of = 4'd5;
            3'd3:    step_in_of = 4'd5;
            3'd4:    step_in_of = 4'd4;
            3'd5:    step_in_of = 4'd8;
            3'd6:    step_in_of = 4'd6;
            default: step_in_of = 4'd1;
        endcase
    endfunction

    function automatic logic [STEP_W-1:0] step_out_of(input logic [CODE_W-1:0] code);
        case (code)
            3'd1:    step_out_of = 4'd4;
            3'd2:    step_out_of = 4'd8;
            3'd3:    step_out_of = 4'd6;
            3'd4:    step_out_of = 4'd3;
            3'd5:    step_out_of = 4'd5;
            3'd6:    step_out_of = 4'd5;
            default: step_out_of = 4'd1;
        endcase
    endfunction

    // Ratios are stacked in code order, each taking step_in addresses.
    function automatic logic [ADDR_W-1:0] base_of(input logic [CODE_W-1:0] code);
        logic [ADDR_W-1:0] acc;
        acc = '0;
        if (code != CODE_W'(NUM_CODES - 1)) begin
            for (int k = 0; k < NUM_CODES - 1; k++) begin
                if (CODE_W'(k) < code) begin
                    acc = acc + ADDR_W'(step_in_of(CODE_W'(k)));
                end
            end
        end
        base_of = acc;
    endfunction

endpackage

// File: rtl/srcpc_slot_ctr.sv
module srcpc_slot_ctr #(
    parameter int NCH  = 8,
    parameter int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [CH_W-1:0] slot
);

    localparam logic [CH_W-1:0] LAST = CH_W'(NCH - 1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot <= '0;
        end else if (slot == LAST) begin
            slot <= '0;
        end else begin
            slot <= slot + 1'b1;
        end
    end

endmodule

// File: rtl/srcpc_ratio_lut.sv
module srcpc_ratio_lut
    import srcpc_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output logic [STEP_W-1:0] step_in,
    output logic [STEP_W-1:0] step_out,
    output logic [ADDR_W-1:0] base_addr
);

    logic [ADDR_W-1:0] base_tab [NUM_CODES];

    // One constant base per code, computed from the stacked layout.
    for (genvar g = 0; g < NUM_CODES; g++) begin : g_base
        assign base_tab[g] = base_of(CODE_W'(g));
    end

    always_comb begin
        step_in   = step_in_of(code);
        step_out  = step_out_of(code);
        base_addr = base_tab[code];
    end

endmodule

// File: rtl/srcpc_phase_step.sv
module srcpc_phase_step
    import srcpc_pkg::*;
(
    input  chan_mode_e        cur_mode,
    input  logic [PH_W-1:0]   cur_phase,
    input  logic              in_valid,
    input  logic [STEP_W-1:0] step_in,
    input  logic [STEP_W-1:0] step_out,
    output logic              shift,
    output logic              vout,
    output chan_mode_e        nxt_mode,
    output logic [PH_W-1:0]   nxt_phase
);

    logic [PH_W:0] sum;
    logic [PH_W:0] sin_w;
    logic          advance;
    logic          consume;

    assign sum   = {1'b0, cur_phase} + (PH_W+1)'(step_out);
    assign sin_w = (PH_W+1)'(step_in);

    always_comb begin
        shift     = 1'b0;
        vout      = 1'b0;
        advance   = 1'b0;
        consume   = 1'b0;
        nxt_mode  = cur_mode;
        nxt_phase = cur_phase;

        unique case (cur_mode)
            MD_HOLD: begin
                vout    = 1'b1;
                advance = 1'b1;
            end
            MD_SKIP: begin
                if (in_valid) begin
                    shift   = 1'b1;
                    consume = 1'b1;
                end
            end
            default: begin
                if (in_valid) begin
                    shift   = 1'b1;
                    vout    = 1'b1;
                    advance = 1'b1;
                end
            end
        endcase

        if (advance) begin
            if (sum < sin_w) begin
                nxt_mode  = MD_HOLD;
                nxt_phase = PH_W'(sum);
            end else begin
                nxt_mode  = ((sum >> 1) >= sin_w) ? MD_SKIP : MD_RUN;
                nxt_phase = PH_W'(sum - sin_w);
            end
        end else if (consume) begin
            nxt_mode  = (({1'b0, cur_phase} >> 1) >= sin_w) ? MD_SKIP : MD_RUN;
            nxt_phase = PH_W'({1'b0, cur_phase} - sin_w);
        end
    end

endmodule

// File: rtl/srcpc_phase_ctrl.sv
module srcpc_phase_ctrl
    import srcpc_pkg::*;
#(
    parameter int NCH  = 8,
    parameter int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [CODE_W-1:0] ratio_code,
    output logic [CH_W-1:0]   slot,
    output logic              shift_en,
    output logic              out_valid,
    output logic [CH_W-1:0]   out_chan,
    output logic [ADDR_W-1:0] coef_addr
);

    logic [PH_W-1:0]   ph_mem [NCH];
    chan_mode_e        md_mem [NCH];
    logic [CODE_W-1:0] cd_mem [NCH];

    logic [STEP_W-1:0] step_in;
    logic [STEP_W-1:0] step_out;
    logic [ADDR_W-1:0] base_addr;
    logic              restart;
    chan_mode_e        cur_mode;
    logic [PH_W-1:0]   cur_phase;
    logic              shift;
    logic              vout;
    chan_mode_e        nxt_mode;
    logic [PH_W-1:0]   nxt_phase;

    srcpc_slot_ctr #(.NCH(NCH), .CH_W(CH_W)) u_slot (
        .clk   (clk),
        .rst_n (rst_n),
        .slot  (slot)
    );

    srcpc_ratio_lut u_lut (
        .code      (ratio_code),
        .step_in   (step_in),
        .step_out  (step_out),
        .base_addr (base_addr)
    );

    // A new ratio code on a channel starts it afresh.
    assign restart   = (ratio_code != cd_mem[slot]);
    assign cur_mode  = restart ? MD_RUN : md_mem[slot];
    assign cur_phase = restart ? '0 : ph_mem[slot];

    srcpc_phase_step u_step (
        .cur_mode  (cur_mode),
        .cur_phase (cur_phase),
        .in_valid  (in_valid),
        .step_in   (step_in),
        .step_out  (step_out),
        .shift     (shift),
        .vout      (vout),
        .nxt_mode  (nxt_mode),
        .nxt_phase (nxt_phase)
    );

    // Per-channel state write-back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NCH; k++) begin
                ph_mem[k] <= '0;
                md_mem[k] <= MD_RUN;
                cd_mem[k] <= '0;
            end
        end else begin
            ph_mem[slot] <= nxt_phase;
            md_mem[slot] <= nxt_mode;
            cd_mem[slot] <= ratio_code;
        end
    end

    // Registered turn results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_en  <= 1'b0;
            out_valid <= 1'b0;
            out_chan  <= '0;
            coef_addr <= '0;
        end else begin
            shift_en  <= shift;
            out_valid <= vout;
            out_chan  <= slot;
            coef_addr <= vout ? (base_addr + ADDR_W'(cur_phase)) : '0;
        end
    end

endmodule

// File: rtl/srcpc_phase_ctrl_chk.sv
module srcpc_phase_ctrl_chk #(
    parameter int NCH    = 8,
    parameter int CH_W   = 3,
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [CH_W-1:0]   slot,
    input logic              shift_en,
    input logic              out_valid,
    input logic [CH_W-1:0]   out_chan,
    input logic [ADDR_W-1:0] coef_addr
);

    p_slot_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (slot == CH_W'(NCH - 1)) |=> (slot == '0));

    p_slot_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (slot != CH_W'(NCH - 1)) |=> (slot == CH_W'($past(slot) + 1'b1)));

    p_no_shift_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !shift_en);

    p_addr_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (coef_addr == '0));

    p_chan_tag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en || out_valid) |-> (out_chan == $past(slot)));

endmodule

bind srcpc_phase_ctrl srcpc_phase_ctrl_chk #(
    .NCH    (NCH),
    .CH_W   (CH_W),
    .ADDR_W (srcpc_pkg::ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .slot      (slot),
    .shift_en  (shift_en),
    .out_valid (out_valid),
    .out_chan  (out_chan),
    .coef_addr (coef_addr)
);

// File: tb/srcpc_phase_ctrl_tb.sv
module srcpc_phase_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 8;
    localparam int CH_W       = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic [2:0]      ratio_code = '0;
    logic [CH_W-1:0] slot;
    logic            shift_en;
    logic            out_valid;
    logic [CH_W-1:0] out_chan;
    logic [4:0]      coef_addr;

    srcpc_phase_ctrl #(.NCH(NCH), .CH_W(CH_W)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .ratio_code (ratio_code),
        .slot       (slot),
        .shift_en   (shift_en),
        .out_valid  (out_valid),
        .out_chan   (out_chan),
        .coef_addr  (coef_addr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Reference state, from the requirements
    int m_ph [NCH];
    int m_md [NCH];          // 0 RUN, 1 HOLD, 2 SKIP
    int m_cd [NCH];
    int cfg_code [NCH];
    logic [7:0] cfg_mask [NCH];
    int o_shift [NCH];
    int o_out [NCH];
    int turn_no;
    int exp_slot;
    bit pend;
    int e_shift, e_vout, e_addr, e_chan;
    string e_tag;

    function automatic int sin_f(int c);
        case (c)
            1: return 3; 2: return 5; 3: return 5;
            4: return 4; 5: return 8; 6: return 6;
            default: return 1;
        endcase
    endfunction

    function automatic int sout_f(int c);
        case (c)
            1: return 4; 2: return 8; 3: return 6;
            4: return 3; 5: return 5; 6: return 5;
            default: return 1;
        endcase
    endfunction

    function automatic int base_f(int c);
        int b = 0;
        if (c == 7) return 0;
        for (int k = 0; k < c; k++) b += sin_f(k);
        return b;
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic turn();
        int s, iv, c, si, so, ph, md, sum, adv, con;
        @(negedge clk);
        if (pend) begin
            check(shift_en == e_shift[0], {e_tag, " shift_en"}, shift_en, e_shift);
            check(out_valid == e_vout[0], {e_tag, " out_valid"}, out_valid, e_vout);
            check(coef_addr == e_addr[4:0], "R8 coef_addr", coef_addr, e_addr);
            check(out_chan == e_chan[CH_W-1:0], "R9 out_chan", out_chan, e_chan);
            o_shift[e_chan] += int'(shift_en);
            o_out[e_chan]   += int'(out_valid);
        end
        s = int'(slot);
        check(s == exp_slot, "R1 slot", s, exp_slot);
        iv = int'(cfg_mask[s][turn_no % 8]);
        c  = cfg_code[s];
        in_valid   = iv[0];
        ratio_code = c[2:0];
        e_tag = "R4";
        if (c != m_cd[s]) begin
            m_ph[s] = 0;
            m_md[s] = 0;
            e_tag = "R10";
        end
        m_cd[s] = c;
        si = sin_f(c); so = sout_f(c);
        ph = m_ph[s]; md = m_md[s];
        e_shift = 0; e_vout = 0; adv = 0; con = 0;
        if (md == 1) begin
            e_vout = 1; adv = 1;
            if (e_tag != "R10") e_tag = "R5";
        end else if (md == 2) begin
            if (iv != 0) begin e_shift = 1; con = 1; end
            if (e_tag != "R10") e_tag = (iv != 0) ? "R6" : "R7";
        end else if (iv != 0) begin
            e_shift = 1; e_vout = 1; adv = 1;
            if (c == 7 && e_tag != "R10") e_tag = "R3";
        end else if (e_tag != "R10") begin
            e_tag = "R7";
        end
        e_addr = (e_vout != 0) ? base_f(c) + ph : 0;
        e_chan = s;
        if (adv != 0) begin
            sum = ph + so;
            if (sum < si) begin
                m_md[s] = 1; m_ph[s] = sum;
            end else begin
                m_md[s] = ((sum >> 1) >= si) ? 2 : 0;
                m_ph[s] = sum - si;
            end
        end else if (con != 0) begin
            m_md[s] = ((ph >> 1) >= si) ? 2 : 0;
            m_ph[s] = ph - si;
        end
        pend = 1'b1;
        turn_no++;
        exp_slot = (s + 1) % NCH;
    endtask

    task automatic do_reset();
        in_valid = 1'b0;
        ratio_code = '0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R2: quiet outputs while in reset
        check(!shift_en && !out_valid && coef_addr == 0 && out_chan == 0,
              "R2 reset outputs", {shift_en, out_valid}, 0);
        check(slot == 0, "R1 slot in reset", slot, 0);
        rst_n = 1'b1;
        for (int k = 0; k < NCH; k++) begin
            m_ph[k] = 0; m_md[k] = 0; m_cd[k] = 0;
            o_shift[k] = 0; o_out[k] = 0;
        end
        turn_no = 0;
        // first edge after release: idle turn of channel 0
        pend = 1'b1;
        e_shift = 0; e_vout = 0; e_addr = 0; e_chan = 0; e_tag = "R2";
        exp_slot = 1;
    endtask

    task automatic t_bypass();
        for (int k = 0; k < NCH; k++) begin
            cfg_code[k] = 0; cfg_mask[k] = 8'hFF;
        end
        do_reset();
        repeat (3 * NCH) turn();
        for (int k = 0; k < NCH; k++)
            check(o_out[k] == o_shift[k], "R3 bypass one output per input", o_out[k], o_shift[k]);
    endtask

    task automatic t_rate_58();
        for (int k = 0; k < NCH; k++) begin
            cfg_code[k] = 0; cfg_mask[k] = 8'h00;
        end
        cfg_code[0] = 2; cfg_mask[0] = 8'hFF;
        do_reset();
        for (int n = 0; n < 400 && o_shift[0] < 8; n++) turn();
        check(o_shift[0] == 8, "R11 5/8 inputs taken", o_shift[0], 8);
        check(o_out[0] == 5, "R11 5/8 outputs", o_out[0], 5);
    endtask

    task automatic t_rate_43();
        for (int k = 0; k < NCH; k++) begin
            cfg_code[k] = 0; cfg_mask[k] = 8'h00;
        end
        cfg_code[0] = 4; cfg_mask[0] = 8'hFF;
        do_reset();
        for (int n = 0; n < 400 && o_shift[0] < 3; n++) turn();
        check(o_out[0] == 4, "R11 4/3 outputs", o_out[0], 4);
    endtask

    task automatic t_mixed();
        logic [7:0] masks [8] = '{8'hFF, 8'hAA, 8'h5B, 8'h77, 8'hC3, 8'hFF, 8'h0F, 8'h99};
        for (int k = 0; k < NCH; k++) begin
            cfg_code[k] = k % 8; cfg_mask[k] = masks[k % 8];
        end
        do_reset();
        repeat (40 * NCH) turn();
    endtask

    task automatic t_ratio_switch();
        // R10: codes change on every channel without a reset
        for (int k = 0; k < NCH; k++) cfg_code[k] = (k + 3) % 8;
        repeat (10 * NCH) turn();
    endtask

    task automatic t_idle_keep();
        logic [7:0] saved [NCH];
        for (int k = 0; k < NCH; k++) begin
            saved[k] = cfg_mask[k]; cfg_mask[k] = 8'h00;
        end
        repeat (3 * NCH) turn();   // R7: nothing moves
        for (int k = 0; k < NCH; k++) cfg_mask[k] = saved[k];
        repeat (6 * NCH) turn();   // state kept across the idle stretch
    endtask

    initial begin
        pend = 1'b0;
        exp_slot = 0;
        turn_no = 0;
        t_bypass();
        t_rate_58();
        t_rate_43();
        t_mixed();
        t_ratio_switch();
        t_idle_keep();
        turn();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired (all requirements)");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule